// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync Data

This block is the transmit data path of a synchronous serial port. Software or a DMA engine writes one word at a time into a holding register. At the start of each word slot the word moves into a shift register. One bit goes out on the serial line for each shift strobe that an external clock divider supplies. A start pulse from an external frame controller opens a frame. The frame carries a programmable number of words. Each word has a programmable length and is sent least significant bit first or most significant bit first.

While the frame controller holds its sync-active signal high, the line can carry a separate sync data word. It can also hold the idle level instead. The idle level applies whenever no real bit is on the line. Two status flags report progress. The ready flag says the holding register can take a word. The empty flag says nothing is left waiting or being shifted. Enable, disable and reset commands arrive as single-cycle pulses.

Top module: `sst_tx`

## Requirements
- R1: After reset `rdy` = 1 and `empty` = 1, the transmitter is disabled, and `txd` equals `cfg_idle`.
- R2: Each word is `cfg_len`+1 bits long (1 to 32). The holding register is right aligned, so bits of `wr_data` above bit `cfg_len` are never sent.
- R3: With `cfg_msb_first` = 0 a word goes out from bit 0 upward. With `cfg_msb_first` = 1 it goes out from bit `cfg_len` downward.
- R4: An accepted start sends `cfg_words`+1 words (1 to 16) back to back, with no gap between words. On the strobe that follows the last bit, the line returns to idle.
- R5: Whenever no real bit is being driven, `txd` follows `cfg_idle` in the same cycle.
- R6: Every strobe on which `sync_act` is 1, counting from the start strobe onward, is a sync slot. With `cfg_sync_en` = 1, sync slot j drives `sync_word[j]` for j ≤ `cfg_sync_len` and drives the idle level after that. With `cfg_sync_en` = 0, all sync slots are idle. The first data word begins on the first strobe on which `sync_act` is 0.
- R7: `rdy` is 1 exactly when the holding register is empty. If a write lands on the same edge on which the shifter takes the held word, the written word is kept and `rdy` stays 0.
- R8: `empty` is 0 while a loaded word is being shifted. It rises on the strobe that ends the last bit of the last loaded word, provided the holding register is empty.
- R9: If the holding register is empty when a word slot begins, the slot lasts `cfg_len`+1 strobes at the idle level, and the word count still advances.
- R10: `cmd_en` enables transmission and `cmd_dis` disables it. When both pulse together, disable wins. A disable ends a running frame on that same edge and leaves the line at idle.
- R11: `cmd_swrst` overrides the other commands. It disables the transmitter, empties the holding register and ends any frame.
- R12: A start is accepted only on an edge where `frm_start` and `bit_stb` are both 1, the transmitter is already enabled, and no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse |
| cmd_swrst | input | 1 | Soft reset pulse |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| frm_start | input | 1 | Frame start pulse from the frame controller |
| sync_act | input | 1 | Sync pulse active |
| wr_en | input | 1 | Holding register write |
| wr_data | input | DW | Word to transmit, right aligned |
| sync_word | input | SW | Sync data bits |
| cfg_len | input | log2(DW) | Word length minus one |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_words | input | log2(NW) | Words per frame minus one |
| cfg_sync_en | input | 1 | Shift sync data during the sync pulse |
| cfg_sync_len | input | log2(SW) | Sync bits minus one |
| cfg_idle | input | 1 | Idle line level |
| txd | output | 1 | Serial data |
| rdy | output | 1 | Holding register empty |
| empty | output | 1 | Nothing held and nothing shifting |

## Verification
Two events can share one clock edge: a host write into the holding register, and the shifter taking the held word at the start of the next slot. The bench provokes this by writing the second word of a two-word frame on the very start strobe that loads the first. It then expects `rdy` to read 0 after that edge, and expects both words to appear complete and in order on `txd`. A second overlap is an enable pulse in the same cycle as a disable or soft reset pulse. The bench judges this by whether a following start is refused, which leaves the held word untouched.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } seq_st_t;
endpackage

// File: rtl/sst_ctl.sv
module sst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_en_i,
  input  logic cmd_dis_i,
  input  logic cmd_swrst_i,
  output logic en_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (cmd_swrst_i)    en_d = 1'b0;
    else if (cmd_dis_i) en_d = 1'b0;
    else if (cmd_en_i)  en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  p_swrst_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_swrst_i |=> !en_o);
  p_dis_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dis_i && cmd_en_i) |=> !en_o);
endmodule

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  // A write on the load edge wins: the old word leaves, the new one stays.
  always_comb begin
    full_d = full_q;
    if (clr_i)       full_d = 1'b0;
    else if (wr_i)   full_d = 1'b1;
    else if (load_i) full_d = 1'b0;
  end

  assign data_en = wr_i && !clr_i;
  assign data_d  = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign full_o = full_q;
  assign data_o = data_q;

  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !full_o);
  p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && load_i && !clr_i) |=> full_o);
endmodule

// File: rtl/sst_seq.sv
module sst_seq
  import sst_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 16,
  parameter int SW = 16,
  localparam int LW  = $clog2(DW),
  localparam int NWW = $clog2(NW),
  localparam int SLW = $clog2(SW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           bit_stb_i,
  input  logic           frm_start_i,
  input  logic           sync_act_i,
  input  logic [LW-1:0]  cfg_len_i,
  input  logic           cfg_msb_i,
  input  logic [NWW-1:0] cfg_words_i,
  input  logic           cfg_sync_en_i,
  input  logic [SLW-1:0] cfg_sync_len_i,
  input  logic [SW-1:0]  sync_word_i,
  input  logic           hold_full_i,
  input  logic [DW-1:0]  hold_data_i,
  output logic           load_o,
  output logic           drive_o,
  output logic           bit_o,
  output logic           busy_o
);
  localparam logic [LW:0]    B_ONE = 1;
  localparam logic [SLW:0]   S_ONE = 1;
  localparam logic [NWW-1:0] W_ONE = 1;

  seq_st_t        st_q, st_d;
  logic [LW:0]    bcnt_q, bcnt_d;
  logic [NWW-1:0] wcnt_q, wcnt_d;
  logic [SLW:0]   scnt_q, scnt_d;
  logic [DW-1:0]  sr_q, sr_d;
  logic           wv_q, wv_d;
  logic           drv_q, drv_d;
  logic           bit_q, bit_d;
  logic           go_word;
  logic [LW:0]    len_ext;
  logic [SLW:0]   slen_ext;

  assign len_ext  = {1'b0, cfg_len_i};
  assign slen_ext = {1'b0, cfg_sync_len_i};

  function automatic logic [LW-1:0] pick(input logic [LW:0] k);
    pick = cfg_msb_i ? (cfg_len_i - k[LW-1:0]) : k[LW-1:0];
  endfunction

  always_comb begin
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    wcnt_d  = wcnt_q;
    scnt_d  = scnt_q;
    sr_d    = sr_q;
    wv_d    = wv_q;
    drv_d   = drv_q;
    bit_d   = bit_q;
    go_word = 1'b0;
    load_o  = 1'b0;
    if (!run_i) begin
      st_d  = ST_IDLE;
      wv_d  = 1'b0;
      drv_d = 1'b0;
    end else if (bit_stb_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (frm_start_i) begin
            wcnt_d = '0;
            if (sync_act_i) begin
              st_d   = ST_SYNC;
              scnt_d = S_ONE;
              drv_d  = cfg_sync_en_i;
              bit_d  = sync_word_i[0];
            end else begin
              go_word = 1'b1;
            end
          end
        end
        ST_SYNC: begin
          if (sync_act_i) begin
            drv_d = cfg_sync_en_i && (scnt_q <= slen_ext);
            bit_d = sync_word_i[scnt_q[SLW-1:0]];
            if (scnt_q <= slen_ext) scnt_d = scnt_q + S_ONE;
          end else begin
            go_word = 1'b1;
          end
        end
        ST_DATA: begin
          if (bcnt_q <= len_ext) begin
            drv_d  = wv_q;
            bit_d  = sr_q[pick(bcnt_q)];
            bcnt_d = bcnt_q + B_ONE;
          end else if (wcnt_q == cfg_words_i) begin
            st_d  = ST_IDLE;
            wv_d  = 1'b0;
            drv_d = 1'b0;
          end else begin
            wcnt_d  = wcnt_q + W_ONE;
            go_word = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (go_word) begin
        st_d   = ST_DATA;
        bcnt_d = B_ONE;
        if (hold_full_i) begin
          load_o = 1'b1;
          sr_d   = hold_data_i;
          wv_d   = 1'b1;
          drv_d  = 1'b1;
          bit_d  = hold_data_i[pick('0)];
        end else begin
          wv_d  = 1'b0;
          drv_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
      wcnt_q <= '0;
      scnt_q <= '0;
      sr_q   <= '0;
      wv_q   <= 1'b0;
      drv_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      wcnt_q <= wcnt_d;
      scnt_q <= scnt_d;
      sr_q   <= sr_d;
      wv_q   <= wv_d;
      drv_q  <= drv_d;
      bit_q  <= bit_d;
    end
  end

  assign drive_o = drv_q;
  assign bit_o   = bit_q;
  assign busy_o  = wv_q;

  p_busy_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (st_q == ST_DATA));
  p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (bcnt_q <= len_ext + B_ONE));
  p_word_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (wcnt_q <= cfg_words_i));
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (st_q == ST_IDLE && !drive_o));
endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
  parameter int DW = 32,
  parameter int NW = 16,
  parameter int SW = 16,
  localparam int LW  = $clog2(DW),
  localparam int NWW = $clog2(NW),
  localparam int SLW = $clog2(SW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_en,
  input  logic           cmd_dis,
  input  logic           cmd_swrst,
  input  logic           bit_stb,
  input  logic           frm_start,
  input  logic           sync_act,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic [SW-1:0]  sync_word,
  input  logic [LW-1:0]  cfg_len,
  input  logic           cfg_msb_first,
  input  logic [NWW-1:0] cfg_words,
  input  logic           cfg_sync_en,
  input  logic [SLW-1:0] cfg_sync_len,
  input  logic           cfg_idle,
  output logic           txd,
  output logic           rdy,
  output logic           empty
);
  logic          en_q;
  logic          run;
  logic          load;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          drive, sbit, busy;

  sst_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_en_i   (cmd_en),
    .cmd_dis_i  (cmd_dis),
    .cmd_swrst_i(cmd_swrst),
    .en_o       (en_q)
  );

  // A disable or soft reset stops the frame on the edge it arrives.
  assign run = en_q && !cmd_dis && !cmd_swrst;

  sst_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cmd_swrst),
    .wr_i   (wr_en),
    .wdata_i(wr_data),
    .load_i (load),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  sst_seq #(.DW(DW), .NW(NW), .SW(SW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .bit_stb_i     (bit_stb),
    .frm_start_i   (frm_start),
    .sync_act_i    (sync_act),
    .cfg_len_i     (cfg_len),
    .cfg_msb_i     (cfg_msb_first),
    .cfg_words_i   (cfg_words),
    .cfg_sync_en_i (cfg_sync_en),
    .cfg_sync_len_i(cfg_sync_len),
    .sync_word_i   (sync_word),
    .hold_full_i   (hold_full),
    .hold_data_i   (hold_data),
    .load_o        (load),
    .drive_o       (drive),
    .bit_o         (sbit),
    .busy_o        (busy)
  );

  assign txd   = drive ? sbit : cfg_idle;
  assign rdy   = !hold_full;
  assign empty = !hold_full && !busy;

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |=> (txd == cfg_idle));
  p_start_needs_stb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !bit_stb && hold_full && !wr_en && !cmd_swrst) |=> !rdy);
endmodule

// File: tb/sst_tx_tb.sv
`timescale 1ns/1ps
module sst_tx_tb;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_en, cmd_dis, cmd_swrst;
  logic        bit_stb, frm_start, sync_act;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [15:0] sync_word;
  logic [4:0]  cfg_len;
  logic        cfg_msb_first;
  logic [3:0]  cfg_words;
  logic        cfg_sync_en;
  logic [3:0]  cfg_sync_len;
  logic        cfg_idle;
  logic        txd, rdy, empty;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] words [16];

  always #4 clk = ~clk;

  sst_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_swrst(cmd_swrst), .bit_stb(bit_stb), .frm_start(frm_start),
    .sync_act(sync_act), .wr_en(wr_en), .wr_data(wr_data),
    .sync_word(sync_word), .cfg_len(cfg_len), .cfg_msb_first(cfg_msb_first),
    .cfg_words(cfg_words), .cfg_sync_en(cfg_sync_en),
    .cfg_sync_len(cfg_sync_len), .cfg_idle(cfg_idle),
    .txd(txd), .rdy(rdy), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_cmd(input logic e, input logic d, input logic s);
    @(negedge clk);
    cmd_en = e; cmd_dis = d; cmd_swrst = s;
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0; cmd_swrst = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One frame: expected bits computed arithmetically per slot.
  task automatic run_frame(input int len, input int msb, input int nw, input int nwr,
                           input int sen, input int slen, input int scyc,
                           input int idle, input int collide);
    int total;
    int written;
    logic exp;
    @(negedge clk);
    cfg_len = len[4:0]; cfg_msb_first = msb[0]; cfg_words = 4'(nw - 1);
    cfg_sync_en = sen[0]; cfg_sync_len = slen[3:0]; cfg_idle = idle[0];
    written = 0;
    if (nwr > 0) begin
      write_word(words[0]);
      written = 1;
    end
    total = scyc + nw * (len + 1) + 1;
    for (int s = 0; s < total; s++) begin
      @(negedge clk);
      bit_stb = 1'b1; frm_start = (s == 0); sync_act = (s < scyc);
      wr_en = (collide != 0 && s == 0);
      if (collide != 0 && s == 0) begin
        wr_data = words[1];
        written = 2;
      end
      @(negedge clk);
      bit_stb = 1'b0; frm_start = 1'b0; sync_act = 1'b0; wr_en = 1'b0;
      if (s < scyc) begin
        exp = (sen != 0 && s <= slen) ? sync_word[s] : idle[0];
        chk("R6 sync slot", {31'b0, txd}, {31'b0, exp});
      end else begin
        int d;
        d = s - scyc;
        if (d < nw * (len + 1)) begin
          int w, k;
          w = d / (len + 1);
          k = d % (len + 1);
          exp = (w < nwr) ? words[w][(msb != 0) ? (len - k) : k] : idle[0];
          if (w < nwr) chk(msb != 0 ? "R3 msb-first bit" : "R2 lsb-first bit",
                           {31'b0, txd}, {31'b0, exp});
          else         chk("R9 empty slot idle", {31'b0, txd}, {31'b0, exp});
          if (k == 0 && w < nwr) chk("R8 empty low while shifting", {31'b0, empty}, 32'd0);
        end else begin
          chk("R4 idle after frame", {31'b0, txd}, {31'b0, idle[0]});
          chk("R8 empty after last bit", {31'b0, empty}, 32'd1);
        end
      end
      if (collide != 0 && s == 0) chk("R7 collision keeps word", {31'b0, rdy}, 32'd0);
      if (rdy && written < nwr) begin
        wr_en = 1'b1; wr_data = words[written];
        written++;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 ready after frame", {31'b0, rdy}, 32'd1);
  endtask

  task automatic fill_words(input int seed);
    for (int i = 0; i < 16; i++) words[i] = (32'h9E37_79B9 * (i + 1)) ^ (seed * 32'h0101_2345);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int lens [5];
    int f;
    lens[0] = 0; lens[1] = 1; lens[2] = 7; lens[3] = 12; lens[4] = 31;
    rst_n = 1'b0; cmd_en = 0; cmd_dis = 0; cmd_swrst = 0; bit_stb = 0;
    frm_start = 0; sync_act = 0; wr_en = 0; wr_data = '0; sync_word = 16'hB4E1;
    cfg_len = 5'd7; cfg_msb_first = 0; cfg_words = 0; cfg_sync_en = 0;
    cfg_sync_len = 0; cfg_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after reset", {31'b0, rdy}, 32'd1);
    chk("R1 empty after reset", {31'b0, empty}, 32'd1);
    chk("R1 txd idle after reset", {31'b0, txd}, 32'd1);
    cfg_idle = 1'b0; #1;
    chk("R5 txd follows idle level", {31'b0, txd}, 32'd0);

    // R12: start while disabled is refused, held word stays
    write_word(32'h5A);
    @(negedge clk); bit_stb = 1; frm_start = 1;
    @(negedge clk); bit_stb = 0; frm_start = 0;
    chk("R12 start refused when disabled", {31'b0, rdy}, 32'd0);
    pulse_cmd(1, 1, 0);
    @(negedge clk); bit_stb = 1; frm_start = 1;
    @(negedge clk); bit_stb = 0; frm_start = 0;
    chk("R10 disable wins over enable", {31'b0, rdy}, 32'd0);
    pulse_cmd(1, 0, 0);
    @(negedge clk); frm_start = 1;
    @(negedge clk); frm_start = 0;
    chk("R12 start without strobe ignored", {31'b0, rdy}, 32'd0);

    // R11: soft reset with enable clears and disables
    pulse_cmd(1, 0, 1);
    chk("R11 soft reset empties holding", {31'b0, rdy}, 32'd1);
    chk("R11 soft reset empty flag", {31'b0, empty}, 32'd1);
    write_word(32'h33);
    @(negedge clk); bit_stb = 1; frm_start = 1;
    @(negedge clk); bit_stb = 0; frm_start = 0;
    chk("R11 disabled after soft reset", {31'b0, rdy}, 32'd0);
    pulse_cmd(0, 0, 1);

    pulse_cmd(1, 0, 0);
    f = 0;
    for (int li = 0; li < 5; li++)
      for (int m = 0; m < 2; m++)
        for (int id = 0; id < 2; id++)
          for (int wi = 0; wi < 2; wi++) begin
            int nw, nwr;
            nw = (wi == 0) ? 1 : 3;
            nwr = ((li + m + id) % 3 == 0) ? nw - 1 : nw;
            fill_words(f);
            run_frame(lens[li], m, nw, nwr, 0, 0, 0, id, 0);
            f++;
          end

    for (int si = 0; si < 3; si++)
      for (int se = 0; se < 2; se++)
        for (int ci = 0; ci < 3; ci++) begin
          int sl, sc;
          sl = (si == 0) ? 0 : (si == 1) ? 3 : 15;
          sc = (ci == 0) ? 1 : (ci == 1) ? sl + 1 : sl + 3;
          fill_words(f);
          run_frame(4, 1, 1, 1, se, sl, sc, se ^ 1, 0);
          f++;
        end

    fill_words(f);
    run_frame(3, 0, 2, 2, 0, 0, 0, 1, 1);

    // R10: disable mid-frame returns line to idle on that edge
    @(negedge clk); cfg_len = 5'd7; cfg_words = 0; cfg_idle = 1'b1;
    write_word(32'h00);
    @(negedge clk); bit_stb = 1; frm_start = 1;
    @(negedge clk); bit_stb = 0; frm_start = 0;
    @(negedge clk); bit_stb = 1;
    @(negedge clk); bit_stb = 0;
    chk("R10 bit driven before disable", {31'b0, txd}, 32'd0);
    @(negedge clk); cmd_dis = 1;
    @(negedge clk); cmd_dis = 0;
    chk("R10 idle right after disable", {31'b0, txd}, 32'd1);
    chk("R10 empty after abort", {31'b0, empty}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule